// File: doc/BRIEF.md
# Power-Fail Reset and Park/Brake Sequencer

This block supervises the supplies of a motor-driver controller. It takes two supply-good flags, one covering the low-voltage logic and analog rails and one covering the high-voltage rail. Each flag arrives with hysteresis already applied but is not yet in the clock domain, so each one passes through a two-flop synchroniser first. While either rail is bad, the block holds two active-low reset outputs low. Once both rails are good, it keeps the resets low for a programmable number of cycles, which takes the place of an external power-on timing capacitor.

A supply fault also starts a safety sequence on its own. The actuator latch drivers are disabled and park is asserted at once. A programmable brake delay then starts. When that delay expires, the brake output is raised, which turns on every low-side pre-driver at the same moment. The fault-triggered brake stays on until both rails are good again and the power-on delay has run out. Separately, a park request bit and a brake request bit from the register interface can force park or brake at any time, with no fault present.

Top module: `pfs_supervisor`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, both reset outputs are 0, `parkEn` is 1, `latchDrvEn` is 0 and `brakeEn` follows `brakeReq` only.
- R2: A 0 on either raw supply flag drives both reset outputs to 0 on the third rising clock edge after the flag is first sampled low.
- R3: The two reset outputs always carry the same value. They rise only after both synchronised flags have been 1 on `porDelay`+1 consecutive clock edges.
- R4: A supply fault that arrives while the power-on delay is counting restarts the count from zero. The full `porDelay`+1 good edges are needed again.
- R5: A supply fault sets `parkEn` to 1 and `latchDrvEn` to 0 on the same edge that pulls the resets low.
- R6: After the park sequence starts, `brakeEn` rises once the sequence has been active on `brakeDelay`+1 clock edges.
- R7: A fault-triggered brake stays on until the resets are released, and it clears on the same edge that releases them.
- R8: `parkReq`=1 sets `parkEn` to 1 and `latchDrvEn` to 0 in the same cycle, with no fault present. When it returns to 0, both outputs go back to their fault-driven values.
- R9: `brakeReq`=1 sets `brakeEn` to 1 in the same cycle, with no effect on the resets or on park.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| lvGoodRaw | input | 1 | Low-voltage rails good, asynchronous |
| hvGoodRaw | input | 1 | High-voltage rail good, asynchronous |
| parkReq | input | 1 | Register bit: request park |
| brakeReq | input | 1 | Register bit: request brake |
| porDelay | input | POR_W | Power-on delay, in cycles minus one |
| brakeDelay | input | BRK_W | Brake delay, in cycles minus one |
| resetCoreN | output | 1 | Active-low reset, primary |
| resetEmuN | output | 1 | Active-low reset, secondary copy |
| latchDrvEn | output | 1 | Actuator latch driver enable |
| parkEn | output | 1 | Actuator park enable |
| brakeEn | output | 1 | All low-side pre-drivers on |

## Verification
A wrong run/hold state shows at the reset outputs on the very next edge. A lost fault flag shows at once as `parkEn` low or `latchDrvEn` high. Counter errors show later. A power-on count that is off by one moves the reset release by one cycle. A brake count that does not restart moves the brake onset. Either error appears within one delay period of its cause. The bench steps a behavioural model alongside the block and compares all five outputs on every cycle, so an error is caught in the cycle where it first shows rather than at the end of a phase.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef struct packed {
    logic porClr;
    logic porInc;
    logic brkClr;
    logic brkInc;
  } pfs_strobe_t;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } pfs_state_t;
endpackage

// File: rtl/pfs_datapath.sv
module pfs_datapath
  import pfs_pkg::*;
#(
  parameter int POR_W = 16,
  parameter int BRK_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       goodRaw,
  input  logic [POR_W-1:0] porDelay,
  input  logic [BRK_W-1:0] brakeDelay,
  input  pfs_strobe_t      strobe,
  output logic             supplyOk,
  output logic             porDone,
  output logic             brkDone
);
  localparam int RAILS = 2;

  logic [RAILS-1:0] goodSync;
  logic [POR_W-1:0] porCnt;
  logic [BRK_W-1:0] brkCnt;

  for (genvar r = 0; r < RAILS; r++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], goodRaw[r]};
    end
    assign goodSync[r] = chain[SYNC_STAGES-1];
  end

  assign supplyOk = &goodSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              porCnt <= '0;
    else if (strobe.porClr) porCnt <= '0;
    else if (strobe.porInc) porCnt <= porCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              brkCnt <= '0;
    else if (strobe.brkClr) brkCnt <= '0;
    else if (strobe.brkInc) brkCnt <= brkCnt + 1'b1;
  end

  assign porDone = (porCnt >= porDelay);
  assign brkDone = (brkCnt >= brakeDelay);

  // R4: a bad supply sample always leaves the power-on count at zero
  a_r4_por_restart: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (porCnt == '0));

  a_r6_brk_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (brkCnt == '1) |=> (brkCnt != '0) || $past(strobe.brkClr));
endmodule

// File: rtl/pfs_control.sv
module pfs_control
  import pfs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyOk,
  input  logic        porDone,
  input  logic        brkDone,
  input  logic        parkReq,
  input  logic        brakeReq,
  output pfs_strobe_t strobe,
  output logic        running,
  output logic        latchDrvEn,
  output logic        parkEn,
  output logic        brakeEn
);
  pfs_state_t state;
  logic faultSeq;
  logic faultBrake;
  logic finishing;

  assign running   = (state == ST_RUN);
  assign finishing = supplyOk && (state == ST_HOLD) && porDone;

  always_comb begin
    strobe.porClr = !supplyOk || finishing;
    strobe.porInc = supplyOk && (state == ST_HOLD) && !porDone;
    strobe.brkClr = !faultSeq || finishing;
    strobe.brkInc = faultSeq && !faultBrake && !brkDone && !finishing;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_HOLD;
      faultSeq   <= 1'b1;
      faultBrake <= 1'b0;
    end else begin
      if (!supplyOk)      state <= ST_HOLD;
      else if (finishing) state <= ST_RUN;

      if (!supplyOk)      faultSeq <= 1'b1;
      else if (finishing) faultSeq <= 1'b0;

      if (finishing)                faultBrake <= 1'b0;
      else if (faultSeq && brkDone) faultBrake <= 1'b1;
    end
  end

  assign parkEn     = faultSeq || parkReq;
  assign latchDrvEn = !parkEn;
  assign brakeEn    = faultBrake || brakeReq;

  // R2: a bad supply sample forces the block into hold on the next edge
  a_r2_fault_holds_reset: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> !running);

  // R5: park on and latch drivers off together with the reset
  a_r5_fault_parks: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (parkEn && !latchDrvEn));

  // R6: fault brake only rises once the delay count is complete
  a_r6_brake_after_delay: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultBrake) |-> $past(brkDone));

  // R7: fault brake only drops together with reset release
  a_r7_brake_until_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultBrake) |-> running);
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
  import pfs_pkg::*;
#(
  parameter int POR_W = 16,
  parameter int BRK_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lvGoodRaw,
  input  logic             hvGoodRaw,
  input  logic             parkReq,
  input  logic             brakeReq,
  input  logic [POR_W-1:0] porDelay,
  input  logic [BRK_W-1:0] brakeDelay,
  output logic             resetCoreN,
  output logic             resetEmuN,
  output logic             latchDrvEn,
  output logic             parkEn,
  output logic             brakeEn
);
  pfs_strobe_t strobe;
  logic supplyOk;
  logic porDone;
  logic brkDone;
  logic running;

  pfs_datapath #(.POR_W(POR_W), .BRK_W(BRK_W), .SYNC_STAGES(2)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .goodRaw    ({hvGoodRaw, lvGoodRaw}),
    .porDelay   (porDelay),
    .brakeDelay (brakeDelay),
    .strobe     (strobe),
    .supplyOk   (supplyOk),
    .porDone    (porDone),
    .brkDone    (brkDone)
  );

  pfs_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .supplyOk   (supplyOk),
    .porDone    (porDone),
    .brkDone    (brkDone),
    .parkReq    (parkReq),
    .brakeReq   (brakeReq),
    .strobe     (strobe),
    .running    (running),
    .latchDrvEn (latchDrvEn),
    .parkEn     (parkEn),
    .brakeEn    (brakeEn)
  );

  assign resetCoreN = running;
  assign resetEmuN  = running;

  // R3: reset release needs the power-on count to be complete
  a_r3_release_after_delay: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetCoreN) |-> $past(porDone) && $past(supplyOk));
endmodule

// File: tb/pfs_supervisor_tb.sv
module pfs_supervisor_tb;
  localparam int POR_W = 16;
  localparam int BRK_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lvGoodRaw = 1'b0, hvGoodRaw = 1'b0, parkReq = 1'b0, brakeReq = 1'b0;
  logic [POR_W-1:0] porDelay = 16'd20;
  logic [BRK_W-1:0] brakeDelay = 16'd8;
  logic resetCoreN, resetEmuN, latchDrvEn, parkEn, brakeEn;

  int testsRun = 0;
  int testsFailed = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  pfs_supervisor #(.POR_W(POR_W), .BRK_W(BRK_W)) u_dut (
    .clk(clk), .rstN(rstN), .lvGoodRaw(lvGoodRaw), .hvGoodRaw(hvGoodRaw),
    .parkReq(parkReq), .brakeReq(brakeReq), .porDelay(porDelay),
    .brakeDelay(brakeDelay), .resetCoreN(resetCoreN), .resetEmuN(resetEmuN),
    .latchDrvEn(latchDrvEn), .parkEn(parkEn), .brakeEn(brakeEn)
  );

  // Behavioural reference: raw history queues and integer counters
  bit lvHist[$], hvHist[$];
  int goodEdges, parkEdges;
  bit mRun, mFault, mBrake;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvHist = '{0, 0}; hvHist = '{0, 0};
      goodEdges = 0; parkEdges = 0;
      mRun = 0; mFault = 1; mBrake = 0;
    end else begin
      bit ok, release_;
      ok = lvHist[0] && hvHist[0];
      release_ = ok && !mRun && (goodEdges >= int'(porDelay));
      if (release_) begin
        mBrake = 0; parkEdges = 0; mFault = 0; mRun = 1; goodEdges = 0;
      end else begin
        if (mFault && parkEdges >= int'(brakeDelay)) mBrake = 1;
        if (!mFault) parkEdges = 0;
        else if (!mBrake && parkEdges < int'(brakeDelay)) parkEdges++;
        if (!ok) begin mFault = 1; mRun = 0; goodEdges = 0; end
        else if (!mRun) goodEdges++;
      end
      void'(lvHist.pop_front()); void'(hvHist.pop_front());
      lvHist.push_back(lvGoodRaw); hvHist.push_back(hvGoodRaw);
    end
  end

  task automatic check1(string what, logic act, logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit expPark;
    expPark = mFault || parkReq;
    check1("resetCoreN", resetCoreN, mRun);
    check1("resetEmuN (R3 pair)", resetEmuN, mRun);
    check1("parkEn", parkEn, expPark);
    check1("latchDrvEn", latchDrvEn, !expPark);
    check1("brakeEn", brakeEn, mBrake || brakeReq);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  initial begin
    // R1: reset state
    curReq = "R1";
    step(3);
    rstN = 1'b1;
    step(1);
    // R3 and R6/R7: power up, brake fires before power-on delay ends
    curReq = "R6";
    lvGoodRaw = 1'b1; hvGoodRaw = 1'b1;
    step(12);
    check1("R6 brake on during power-up", brakeEn, 1'b1);
    curReq = "R7";
    step(10);
    curReq = "R3";
    step(10);
    check1("R3 released", resetCoreN, 1'b1);
    check1("R7 brake cleared", brakeEn, 1'b0);
    // R2/R5: high-voltage rail fault
    curReq = "R2";
    hvGoodRaw = 1'b0;
    step(2);
    check1("R2 still high two edges", resetCoreN, 1'b1);
    step(1);
    check1("R2 low on third edge", resetCoreN, 1'b0);
    curReq = "R5";
    check1("R5 park", parkEn, 1'b1);
    step(15);
    hvGoodRaw = 1'b1;
    // R4: glitch during power-on count
    curReq = "R4";
    step(10);
    lvGoodRaw = 1'b0;
    step(2);
    lvGoodRaw = 1'b1;
    step(22);
    check1("R4 still held after restart", resetCoreN, 1'b0);
    step(10);
    check1("R4 released", resetCoreN, 1'b1);
    // R8: park by request
    curReq = "R8";
    parkReq = 1'b1;
    step(4);
    check1("R8 latch off", latchDrvEn, 1'b0);
    parkReq = 1'b0;
    step(2);
    // R9: brake by request
    curReq = "R9";
    brakeReq = 1'b1;
    step(4);
    check1("R9 brake on", brakeEn, 1'b1);
    check1("R9 reset unaffected", resetCoreN, 1'b1);
    brakeReq = 1'b0;
    // R6: short brake delay, single-cycle low rail, different delays
    curReq = "R6";
    porDelay = 16'd3; brakeDelay = 16'd0;
    hvGoodRaw = 1'b0;
    step(1);
    hvGoodRaw = 1'b1;
    step(12);
    // R2: both rails at once
    curReq = "R2";
    lvGoodRaw = 1'b0; hvGoodRaw = 1'b0;
    brakeDelay = 16'd5;
    step(9);
    lvGoodRaw = 1'b1; hvGoodRaw = 1'b1;
    step(10);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #100000;
    testsFailed++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule